// File: doc/BRIEF.md
# DRAM rank CKE power controller

This block drives the clock-enable line of each of four DDR3 ranks and decides, cycle by cycle, whether every rank is powered, powered down, or in self-refresh. After reset it keeps every clock-enable low until software sets an enable bit. From then on it counts idle cycles per rank and drops a quiet rank into power-down. A mode bit chooses how this is done. In one mode clock-enable drops at once and pages stay open. In the other mode the block first requests a precharge of all banks and drops clock-enable only when that precharge completes.

Around each refresh the block raises every rank and grants the refresh after a fixed exit delay. When the refresh ends it drops every rank again. When the package reports a deep idle state (C3 or C6) and no rank has a request, all ranks go into self-refresh. A suspend request first waits for a flush to finish and then parks all ranks in self-refresh until the request is withdrawn. Command timing and the DRAM command bus belong to the surrounding controller.

Top module: `cke_rank_pm`

## Requirements
- R1: While `rst_n` is low, and after reset until `cfg_cke_en` has been sampled high, every `cke` bit and every `rank_rdy` bit is 0.
- R2: At the first clock edge that samples `cfg_cke_en` high, all ranks come up together: `cke` and `rank_rdy` are all ones after that edge.
- R3: With `cfg_dyn_en` high and `cfg_pchg_mode` low, a rank whose `rank_req` bit has been low at `cfg_idle_thr` consecutive edges drops its `cke` at the next edge. A request at any edge restarts the count from zero.
- R4: With `cfg_pchg_mode` high, an idle rank raises its `pchg_req` bit instead and keeps `cke` high, with `rank_rdy` low. The rank drops `cke` at the edge that samples its `pchg_done` bit. If a request arrives first, the rank returns to ready instead.
- R5: A request to a powered-down rank raises its `cke` at that edge. The rank's `rank_rdy` rises exactly 4 edges later.
- R6: A `ref_req` raises every `cke` at the next edge, and `ref_ack` follows 4 edges after that. The edge that samples `ref_done` ends the refresh. Every rank then drops to power-down if `cfg_dyn_en` is high, or returns ready if it is low.
- R7: With `pkg_state` at 3 (C3) or 4 (C6) and `rank_req` all zero, all ranks enter self-refresh at the next edge: `sr_active` goes to 1 and `cke` goes to all zeros. While any request is pending, per-rank power-down applies instead.
- R8: With `pkg_state` at 0 (C0), 1 (C1) or 2 (C1E), self-refresh is never entered, whatever the requests.
- R9: Self-refresh ends at the edge that samples any request, `pkg_state` 0 or `susp_req`. That edge raises every `cke`, and `rank_rdy` goes all ones `cfg_sr_exit_dly`+1 edges later.
- R10: While in self-refresh, `ref_req` is not acknowledged and `cke` stays all zeros.
- R11: `susp_req` in normal operation waits for `flush_done`, keeping ranks running meanwhile. At that edge `cke` drops to all zeros and `susp_ack` and `sr_active` go to 1. They stay so despite requests until `susp_req` falls, and the exit then follows R9.
- R12: With `cfg_dyn_en` low, no rank is powered down for idleness.
- R13: When several events coincide in normal operation, a suspend request wins over a refresh request, and a refresh request wins over deep-idle self-refresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cke_en | input | 1 | Software enable that releases clock-enable after reset |
| cfg_dyn_en | input | 1 | Enables idle power-down and power-down after refresh |
| cfg_pchg_mode | input | 1 | 0: drop clock-enable with pages open; 1: precharge first |
| cfg_idle_thr | input | 16 | Idle edges before a rank powers down |
| cfg_sr_exit_dly | input | 8 | Self-refresh exit delay, in edges minus one |
| pkg_state | input | 3 | Package state: 0 C0, 1 C1, 2 C1E, 3 C3, 4 C6 |
| rank_req | input | 4 | Pending request per rank |
| pchg_done | input | 4 | Precharge-all completion per rank |
| ref_req | input | 1 | Refresh due, held until acknowledged |
| ref_done | input | 1 | Refresh finished |
| susp_req | input | 1 | Suspend-to-RAM request, held for the whole suspend |
| flush_done | input | 1 | Pending cycles flushed |
| cke | output | 4 | Clock-enable per rank |
| rank_rdy | output | 4 | Rank powered and usable |
| pchg_req | output | 4 | Precharge-all request per rank |
| ref_ack | output | 1 | All ranks up, refresh may run |
| sr_active | output | 1 | Ranks held in self-refresh |
| susp_ack | output | 1 | Suspend reached |

## Verification
The checks inside the design assume that the neighbouring logic behaves well. `pchg_done` pulses only for a rank whose `pchg_req` is raised, and `ref_req` is held until `ref_ack` and then drops together with a one-cycle `ref_done`. `flush_done` comes only during a pending suspend. The mode bit changes only while no rank sits in precharge. The stimulus follows these rules: each completion is driven only in the state that awaits it, refresh and suspend handshakes are played in order, and configuration changes are made only while all ranks are powered down or ready.

// File: rtl/cke_rank_pm.sv
module cke_rank_pm #(
  parameter int RANKS    = 4,
  parameter int IDLE_W   = 16,
  parameter int XDLY_W   = 8,
  parameter int EXIT_CYC = 4,
  parameter int PKG_W    = 3,
  parameter logic [PKG_W-1:0] PKG_C0 = 3'd0,
  parameter logic [PKG_W-1:0] PKG_C3 = 3'd3,
  parameter logic [PKG_W-1:0] PKG_C6 = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cke_en,
  input  logic              cfg_dyn_en,
  input  logic              cfg_pchg_mode,
  input  logic [IDLE_W-1:0] cfg_idle_thr,
  input  logic [XDLY_W-1:0] cfg_sr_exit_dly,
  input  logic [PKG_W-1:0]  pkg_state,
  input  logic [RANKS-1:0]  rank_req,
  input  logic [RANKS-1:0]  pchg_done,
  input  logic              ref_req,
  input  logic              ref_done,
  input  logic              susp_req,
  input  logic              flush_done,
  output logic [RANKS-1:0]  cke,
  output logic [RANKS-1:0]  rank_rdy,
  output logic [RANKS-1:0]  pchg_req,
  output logic              ref_ack,
  output logic              sr_active,
  output logic              susp_ack
);

  localparam int WCW = $clog2(EXIT_CYC) + 1;
  localparam int GCW = (XDLY_W > WCW) ? XDLY_W : WCW;

  typedef enum logic [2:0] {
    G_OFF, G_RUN, G_REFW, G_REF, G_SR, G_SREXIT, G_FLUSH, G_SUSP
  } gst_t;

  typedef enum logic [1:0] {R_UP, R_PCHG, R_PD, R_WAKE} rk_t;

  gst_t           g, g_nxt;
  logic [GCW-1:0] gcnt;
  logic [GCW-1:0] sr_lim, wk_lim;
  logic           deep, any_req, rank_active, force_hi, sr_leave, ref_end;

  assign sr_lim      = GCW'(cfg_sr_exit_dly);
  assign wk_lim      = GCW'(EXIT_CYC - 1);
  assign deep        = (pkg_state == PKG_C3) || (pkg_state == PKG_C6);
  assign any_req     = |rank_req;
  assign rank_active = (g == G_RUN) || (g == G_FLUSH);
  assign force_hi    = (g == G_REFW) || (g == G_REF) || (g == G_SREXIT);
  assign sr_leave    = (g == G_SREXIT) && (gcnt == sr_lim);
  assign ref_end     = (g == G_REF) && ref_done;

  assign ref_ack   = (g == G_REF);
  assign sr_active = (g == G_SR) || (g == G_SUSP);
  assign susp_ack  = (g == G_SUSP);

  always_comb begin
    g_nxt = g;
    case (g)
      G_OFF:    if (cfg_cke_en) g_nxt = G_RUN;
      G_RUN: begin
        if (susp_req)              g_nxt = G_FLUSH;
        else if (ref_req)          g_nxt = G_REFW;
        else if (deep && !any_req) g_nxt = G_SR;
      end
      G_REFW:   if (gcnt == wk_lim) g_nxt = G_REF;
      G_REF:    if (ref_done) g_nxt = G_RUN;
      G_SR:     if (any_req || pkg_state == PKG_C0 || susp_req) g_nxt = G_SREXIT;
      G_SREXIT: if (sr_leave) g_nxt = G_RUN;
      G_FLUSH:  if (flush_done) g_nxt = G_SUSP;
      G_SUSP:   if (!susp_req) g_nxt = G_SREXIT;
      default:  g_nxt = G_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g    <= G_OFF;
      gcnt <= '0;
    end else begin
      g <= g_nxt;
      if (g_nxt != g) gcnt <= '0;
      else if (g == G_REFW || g == G_SREXIT) gcnt <= gcnt + 1'b1;
    end
  end

  for (genvar i = 0; i < RANKS; i++) begin : g_rank
    rk_t              st;
    logic [IDLE_W-1:0] icnt;
    logic [WCW-1:0]    wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st   <= R_UP;
        icnt <= '0;
        wcnt <= '0;
      end else if (sr_leave) begin
        st   <= R_UP;
        icnt <= '0;
      end else if (ref_end) begin
        st   <= cfg_dyn_en ? R_PD : R_UP;
        icnt <= '0;
      end else if (rank_active) begin
        case (st)
          R_UP: begin
            if (rank_req[i]) icnt <= '0;
            else if (cfg_dyn_en && icnt >= cfg_idle_thr) begin
              st   <= cfg_pchg_mode ? R_PCHG : R_PD;
              icnt <= '0;
            end else if (~&icnt) icnt <= icnt + 1'b1;
          end
          R_PCHG: begin
            if (rank_req[i]) begin
              st   <= R_UP;
              icnt <= '0;
            end else if (pchg_done[i]) st <= R_PD;
          end
          R_PD: begin
            if (rank_req[i]) begin
              st   <= R_WAKE;
              wcnt <= '0;
            end
          end
          default: begin
            if (wcnt == WCW'(EXIT_CYC - 1)) begin
              st   <= R_UP;
              icnt <= '0;
            end else wcnt <= wcnt + 1'b1;
          end
        endcase
      end
    end

    assign cke[i]      = force_hi || (rank_active && st != R_PD);
    assign rank_rdy[i] = rank_active && st == R_UP;
    assign pchg_req[i] = rank_active && st == R_PCHG;

    AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (rank_active && st == R_PD && rank_req[i]) |=> (cke[i] && !rank_rdy[i])); // R5

    AST_PD_AFTER_PCHG: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cke[i]) && rank_active && $past(rank_active) && $past(cfg_pchg_mode))
        |-> $past(pchg_done[i])); // R4
  end

  AST_CKE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cke != '0) |-> ($past(cfg_cke_en) || $past(cke != '0))); // R1

  AST_REF_RANKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ack) |-> $past(&cke)); // R6

  AST_SR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sr_active) && !susp_ack)
      |-> ($past(rank_req) == '0 && ($past(pkg_state) == PKG_C3 || $past(pkg_state) == PKG_C6))); // R7

  AST_SUSP_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_ack) |-> $past(flush_done)); // R11

endmodule

// File: tb/test_cke_rank_pm.sv
module test_cke_rank_pm;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_cke_en, cfg_dyn_en, cfg_pchg_mode;
  logic [15:0] cfg_idle_thr;
  logic [7:0]  cfg_sr_exit_dly;
  logic [2:0]  pkg_state;
  logic [3:0]  rank_req, pchg_done;
  logic        ref_req, ref_done, susp_req, flush_done;
  logic [3:0]  cke, rank_rdy, pchg_req;
  logic        ref_ack, sr_active, susp_ack;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // row: {rank_req, pkg_state, expected cke, expected rank_rdy, expected sr_active}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b1111, 3'd0, 4'b1111, 4'b1111, 1'b0},
    {4'b0001, 3'd0, 4'b1111, 4'b1111, 1'b0},
    {4'b0001, 3'd0, 4'b1111, 4'b1111, 1'b0},
    {4'b0001, 3'd0, 4'b1111, 4'b1111, 1'b0},
    {4'b0001, 3'd0, 4'b0001, 4'b0001, 1'b0},
    {4'b0010, 3'd0, 4'b0011, 4'b0001, 1'b0},
    {4'b0010, 3'd0, 4'b0011, 4'b0001, 1'b0},
    {4'b0010, 3'd0, 4'b0011, 4'b0001, 1'b0},
    {4'b0010, 3'd0, 4'b0010, 4'b0000, 1'b0},
    {4'b0000, 3'd0, 4'b0010, 4'b0010, 1'b0},
    {4'b0000, 3'd0, 4'b0010, 4'b0010, 1'b0},
    {4'b0010, 3'd0, 4'b0010, 4'b0010, 1'b0},
    {4'b0000, 3'd0, 4'b0010, 4'b0010, 1'b0},
    {4'b0000, 3'd0, 4'b0010, 4'b0010, 1'b0},
    {4'b0000, 3'd0, 4'b0010, 4'b0010, 1'b0},
    {4'b0000, 3'd0, 4'b0000, 4'b0000, 1'b0},
    {4'b1100, 3'd1, 4'b1100, 4'b0000, 1'b0},
    {4'b0000, 3'd1, 4'b1100, 4'b0000, 1'b0},
    {4'b0000, 3'd1, 4'b1100, 4'b0000, 1'b0},
    {4'b0000, 3'd1, 4'b1100, 4'b0000, 1'b0},
    {4'b0000, 3'd1, 4'b1100, 4'b1100, 1'b0},
    {4'b0000, 3'd2, 4'b1100, 4'b1100, 1'b0},
    {4'b0000, 3'd2, 4'b1100, 4'b1100, 1'b0},
    {4'b0000, 3'd2, 4'b1100, 4'b1100, 1'b0},
    {4'b0000, 3'd2, 4'b0000, 4'b0000, 1'b0}
  };

  cke_rank_pm i_cke_rank_pm (
    .clk(clk), .rst_n(rst_n), .cfg_cke_en(cfg_cke_en), .cfg_dyn_en(cfg_dyn_en),
    .cfg_pchg_mode(cfg_pchg_mode), .cfg_idle_thr(cfg_idle_thr),
    .cfg_sr_exit_dly(cfg_sr_exit_dly), .pkg_state(pkg_state), .rank_req(rank_req),
    .pchg_done(pchg_done), .ref_req(ref_req), .ref_done(ref_done), .susp_req(susp_req),
    .flush_done(flush_done), .cke(cke), .rank_rdy(rank_rdy), .pchg_req(pchg_req),
    .ref_ack(ref_ack), .sr_active(sr_active), .susp_ack(susp_ack)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_cke_en = 1'b0; cfg_dyn_en = 1'b1; cfg_pchg_mode = 1'b0;
    cfg_idle_thr = 16'd3; cfg_sr_exit_dly = 8'd2; pkg_state = 3'd0;
    rank_req = '0; pchg_done = '0; ref_req = 1'b0; ref_done = 1'b0;
    susp_req = 1'b0; flush_done = 1'b0;

    tick(3);
    chk("R1 cke in reset", cke, 4'b0000);
    chk("R1 rdy in reset", rank_rdy, 4'b0000);
    rst_n = 1'b1;
    tick(3);
    chk("R1 cke before enable", cke, 4'b0000);
    chk("R1 rdy before enable", rank_rdy, 4'b0000);
    cfg_cke_en = 1'b1;
    tick(1);
    chk("R2 cke after enable", cke, 4'b1111);
    chk("R2 rdy after enable", rank_rdy, 4'b1111);

    // R3, R5, R8: idle power-down, wake delay, shallow states
    for (int k = 0; k < NVEC; k++) begin
      rank_req  = VEC[k][15:12];
      pkg_state = VEC[k][11:9];
      tick(1);
      chk($sformatf("R3/R5 row %0d cke", k), cke, VEC[k][8:5]);
      chk($sformatf("R3/R5 row %0d rdy", k), rank_rdy, VEC[k][4:1]);
      chk($sformatf("R8 row %0d sr", k), sr_active, VEC[k][0]);
    end
    rank_req = '0; pkg_state = 3'd0;

    // R6: refresh with dynamic power-down enabled
    ref_req = 1'b1;
    tick(1);
    chk("R6 cke raised", cke, 4'b1111);
    tick(3);
    chk("R6 ack not yet", ref_ack, 1'b0);
    tick(1);
    chk("R6 ack", ref_ack, 1'b1);
    ref_req = 1'b0; ref_done = 1'b1;
    tick(1);
    ref_done = 1'b0;
    chk("R6 cke dropped after refresh", cke, 4'b0000);

    // R4: precharge power-down
    cfg_pchg_mode = 1'b1;
    rank_req = 4'b0001;
    tick(1);
    rank_req = '0;
    tick(4);
    chk("R4 rank0 ready", rank_rdy, 4'b0001);
    tick(4);
    chk("R4 pchg request", pchg_req, 4'b0001);
    chk("R4 cke held", cke, 4'b0001);
    chk("R4 rdy during precharge", rank_rdy, 4'b0000);
    tick(2);
    chk("R4 cke waits for done", cke, 4'b0001);
    rank_req = 4'b0001;
    tick(1);
    rank_req = '0;
    chk("R4 cancel pchg", pchg_req, 4'b0000);
    chk("R4 cancel rdy", rank_rdy, 4'b0001);
    tick(4);
    chk("R4 pchg again", pchg_req, 4'b0001);
    pchg_done = 4'b0001;
    tick(1);
    pchg_done = '0;
    chk("R4 cke low after done", cke, 4'b0000);
    chk("R4 pchg cleared", pchg_req, 4'b0000);
    cfg_pchg_mode = 1'b0;

    // R7, R9, R10: self-refresh
    pkg_state = 3'd3; rank_req = 4'b0100;
    tick(2);
    chk("R7 no SR with request", sr_active, 1'b0);
    chk("R7 per-rank wake", cke, 4'b0100);
    rank_req = '0;
    tick(1);
    chk("R7 SR on C3", sr_active, 1'b1);
    chk("R7 cke low in SR", cke, 4'b0000);
    ref_req = 1'b1;
    tick(3);
    chk("R10 no ref ack in SR", ref_ack, 1'b0);
    chk("R10 cke low in SR", cke, 4'b0000);
    ref_req = 1'b0;
    pkg_state = 3'd0;
    tick(1);
    chk("R9 exit cke", cke, 4'b1111);
    chk("R9 exit sr", sr_active, 1'b0);
    tick(2);
    chk("R9 rdy not yet", rank_rdy, 4'b0000);
    tick(1);
    chk("R9 rdy after delay", rank_rdy, 4'b1111);
    pkg_state = 3'd4;
    tick(1);
    chk("R7 SR on C6", sr_active, 1'b1);
    rank_req = 4'b0010;
    tick(1);
    rank_req = '0;
    chk("R9 request exit cke", cke, 4'b1111);
    tick(3);
    chk("R9 request exit rdy", rank_rdy, 4'b1111);
    tick(1);
    chk("R7 re-enter SR", sr_active, 1'b1);
    pkg_state = 3'd0;
    tick(4);
    chk("R9 back to run", rank_rdy, 4'b1111);

    // R13: suspend wins over refresh
    susp_req = 1'b1; ref_req = 1'b1;
    tick(1);
    ref_req = 1'b0;
    chk("R13 no refresh during flush", cke, 4'b1111);
    tick(4);
    chk("R13 ref not acked", ref_ack, 1'b0);
    // R11: suspend
    chk("R11 no ack before flush", susp_ack, 1'b0);
    flush_done = 1'b1;
    tick(1);
    flush_done = 1'b0;
    chk("R11 susp ack", susp_ack, 1'b1);
    chk("R11 cke low", cke, 4'b0000);
    rank_req = 4'b0001;
    tick(3);
    rank_req = '0;
    chk("R11 cke stays low", cke, 4'b0000);
    susp_req = 1'b0;
    tick(1);
    chk("R11 exit cke", cke, 4'b1111);
    tick(3);
    chk("R11 exit rdy", rank_rdy, 4'b1111);

    // R13: refresh wins over deep-idle self-refresh
    pkg_state = 3'd3; ref_req = 1'b1;
    tick(1);
    chk("R13 refresh before SR", sr_active, 1'b0);
    tick(4);
    chk("R13 ref ack", ref_ack, 1'b1);
    ref_req = 1'b0; ref_done = 1'b1; pkg_state = 3'd0;
    tick(1);
    ref_done = 1'b0;
    rank_req = 4'b1111;
    tick(1);
    rank_req = '0;
    tick(4);

    // R12: dynamic power-down disabled
    cfg_dyn_en = 1'b0;
    tick(10);
    chk("R12 cke stays up", cke, 4'b1111);
    chk("R12 rdy stays up", rank_rdy, 4'b1111);
    ref_req = 1'b1;
    tick(5);
    chk("R6 ack with dyn off", ref_ack, 1'b1);
    ref_req = 1'b0; ref_done = 1'b1;
    tick(1);
    ref_done = 1'b0;
    chk("R6 ranks ready after refresh", rank_rdy, 4'b1111);

    // R1: reset during operation
    rst_n = 1'b0;
    tick(1);
    chk("R1 cke low on reset", cke, 4'b0000);
    rst_n = 1'b1;
    tick(1);
    chk("R2 enable after reset", cke, 4'b1111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule